// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming Ethernet frame should be kept. It looks only at the 6-byte destination address, the frame length and a few configuration flags. Payload bytes never pass through it. A strobe hands it one destination address together with the frame length. A serial CRC-32 engine then hashes the address one byte per clock. A fixed number of cycles later, a one-cycle result reports accept or reject. The result also flags whether the accepted frame was a group frame, meaning broadcast or multicast.

Multicast frames are checked against a 64-entry hash table held inside the block. Software fills the table by announcing a list length in bytes and then streaming the list's addresses one at a time. Each streamed address is hashed by the same CRC engine, and the table bit it selects is set. The decision rules are applied in a fixed priority order: length first, then promiscuous mode, then broadcast, then multicast, then an exact match against the station address.

Top module: `da_filter`

## Requirements
- R1: After a check strobe is taken on a rising edge, `res_valid` is high for exactly one cycle, starting right after the 7th following edge. While `res_valid` is high, exactly one of `res_accept` and `res_reject` is high. While it is low, `res_accept`, `res_reject` and `res_group` are all low.
- R2: The effective minimum length is `cfg_min_len`, raised to 5 when that value is below 5. A frame whose `chk_len` is below the effective minimum is rejected in every mode, and this rule takes precedence over all others.
- R3: With `cfg_promisc` high, every frame of sufficient length is accepted, and `res_group` stays low.
- R4: A destination of all ones (`48'hFFFF_FFFF_FFFF`) is broadcast. It is rejected when `cfg_bcast_off` is high. Otherwise it is accepted with `res_group` high.
- R5: Any other destination whose first byte has bit 0 set (`chk_dest[40]`) is multicast. It is rejected when `cfg_mcast_en` is low. When `cfg_mcast_en` is high, it is accepted with `res_group` high only if its hashed table bit is set; otherwise it is rejected.
- R6: Any remaining destination is accepted, with `res_group` low, only when it equals `station_addr`; otherwise it is rejected.
- R7: The hash is computed as follows.
  - The CRC-32 uses the reflected polynomial 32'hEDB88320, starts from all ones and has no final inversion.
  - Bytes are fed first byte first, that is `[47:40]` down to `[7:0]`, each byte least significant bit first.
  - The table index is CRC bits 7:2.
- R8: A pulse on `ml_start` clears the whole table. It also sets a load quota of `ml_bytes/6`, capped at 64. Each load strobe taken while the quota is nonzero sets the hashed bit of `ml_addr` and uses up one unit of quota. Load strobes arriving with the quota at zero are ignored.
- R9: A strobe of either kind arriving while an earlier strobe is still in flight is ignored. An earlier strobe is in flight through the 7th edge after the one that took it. When `chk_valid` and `ml_valid` arrive together, the check is taken and the load strobe is ignored.
- R10: After a synchronous reset, all result outputs are low, the hash table is empty and the load quota is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_promisc | input | 1 | Accept every frame of sufficient length |
| cfg_bcast_off | input | 1 | Reject broadcast frames |
| cfg_mcast_en | input | 1 | Allow multicast frames through the hash table |
| cfg_min_len | input | 8 | Minimum frame length (floor of 5 applied) |
| station_addr | input | 48 | Own unicast address, first byte in [47:40] |
| chk_valid | input | 1 | Check strobe |
| chk_dest | input | 48 | Destination address to check, first byte in [47:40] |
| chk_len | input | LEN_W | Frame length in bytes |
| ml_start | input | 1 | Clear table and set load quota |
| ml_bytes | input | CNT_W | Multicast list length in bytes |
| ml_valid | input | 1 | Load strobe for one list address |
| ml_addr | input | 48 | Multicast address to add to the table |
| res_valid | output | 1 | Result strobe |
| res_accept | output | 1 | Frame accepted |
| res_reject | output | 1 | Frame rejected |
| res_group | output | 1 | Accepted frame is broadcast or multicast |

## Verification
The bench builds the block with its default parameters: a 14-bit length, a 6-bit hash index (a 64-bit table) and a 16-bit list byte count. With these values the 64-entry quota cap can be exercised in full: the bench streams a 65th address and confirms it is not added to the table. The same settings let the short-length floor of 5 be reached from both sides. A reference CRC model selects multicast addresses whose hash bits are known to be clear, so table misses are tested deliberately rather than by chance.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam logic [31:0] CRC_POLY      = 32'hEDB88320;
  localparam int          MIN_LEN_FLOOR = 5;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CHECK = 2'd1,
    OP_LOAD  = 2'd2
  } op_e;

  // One byte of reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/daf_crc_serial.sv
module daf_crc_serial #(
  parameter int NBYTES = 6,
  parameter int HASH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [8*NBYTES-1:0]   din,
  output logic                  busy,
  output logic                  done,
  output logic [HASH_W-1:0]     hash_idx
);
  import daf_pkg::*;

  localparam int DW = 8 * NBYTES;
  localparam int CW = $clog2(NBYTES + 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;
  logic [31:0]   crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      crc_q  <= '1;
    end else begin
      done_q <= 1'b0;
      if (start && !run_q && !done_q) begin
        sh_q  <= din;
        crc_q <= '1;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        crc_q <= crc_byte(crc_q, sh_q[DW-1 -: 8]);
        sh_q  <= sh_q << 8;
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(NBYTES - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = run_q | done_q;
  assign done     = done_q;
  assign hash_idx = crc_q[HASH_W+1:2];

  // R1: completion is a single-cycle event that follows a run
  a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r1_done_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(run_q));
  // R9: a run cannot be restarted, it only ends in completion
  a_r9_run_hold: assert property (@(posedge clk) disable iff (rst)
    run_q |=> (run_q ^ done_q));

endmodule

// File: rtl/daf_hash_table.sv
module daf_hash_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int NBITS = 1 << IDX_W;

  logic [NBITS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bits_q <= '0;
    end else if (set_en) begin
      bits_q[set_idx] <= 1'b1;
    end
  end

  assign rd_bit = bits_q[rd_idx];

  // R8: a clear empties the table even when a set arrives alongside it
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bits_q == '0));
  a_r8_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr) |=> bits_q[$past(set_idx)]);

endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
  parameter int MAC_W = 48,
  parameter int LEN_W = 14
) (
  input  logic [MAC_W-1:0] dest,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       min_len,
  input  logic             promisc,
  input  logic             bcast_off,
  input  logic             mcast_en,
  input  logic [MAC_W-1:0] station,
  input  logic             hash_hit,
  output logic             accept,
  output logic             group
);
  import daf_pkg::*;

  logic [7:0]       min_eff;
  logic [LEN_W-1:0] min_ext;
  logic             is_bc;
  logic             is_mc;

  always_comb begin
    min_eff = (min_len < 8'(MIN_LEN_FLOOR)) ? 8'(MIN_LEN_FLOOR) : min_len;
    min_ext = {{(LEN_W-8){1'b0}}, min_eff};
    is_bc   = &dest;
    is_mc   = dest[MAC_W-8];
    accept  = 1'b0;
    group   = 1'b0;
    if (len < min_ext) begin
      accept = 1'b0;
    end else if (promisc) begin
      accept = 1'b1;
    end else if (is_bc) begin
      accept = !bcast_off;
      group  = !bcast_off;
    end else if (is_mc) begin
      accept = mcast_en && hash_hit;
      group  = mcast_en && hash_hit;
    end else begin
      accept = (dest == station);
    end
  end

endmodule

// File: rtl/da_filter.sv
module da_filter #(
  parameter int LEN_W  = 14,
  parameter int HASH_W = 6,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_promisc,
  input  logic             cfg_bcast_off,
  input  logic             cfg_mcast_en,
  input  logic [7:0]       cfg_min_len,
  input  logic [47:0]      station_addr,
  input  logic             chk_valid,
  input  logic [47:0]      chk_dest,
  input  logic [LEN_W-1:0] chk_len,
  input  logic             ml_start,
  input  logic [CNT_W-1:0] ml_bytes,
  input  logic             ml_valid,
  input  logic [47:0]      ml_addr,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_reject,
  output logic             res_group
);
  import daf_pkg::*;

  localparam int NBYTES = 6;
  localparam int MAC_W  = 8 * NBYTES;
  localparam int TBL    = 1 << HASH_W;
  localparam int QW     = $clog2(TBL + 1);

  logic              busy, done;
  logic [HASH_W-1:0] idx;
  logic              hit;
  logic              take_chk, take_ml;
  op_e               op_q;
  logic [MAC_W-1:0]  dest_q;
  logic [LEN_W-1:0]  len_q;
  logic [QW-1:0]     quota_q, quota_cap;
  logic [CNT_W-1:0]  entries;
  logic              dec_acc, dec_grp;

  assign take_chk = chk_valid && !busy;
  assign take_ml  = ml_valid && !chk_valid && !busy && !ml_start && (quota_q != '0);

  always_comb begin
    entries   = ml_bytes / CNT_W'(NBYTES);
    quota_cap = (entries > CNT_W'(TBL)) ? QW'(TBL) : QW'(entries);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_NONE;
      dest_q  <= '0;
      len_q   <= '0;
      quota_q <= '0;
    end else begin
      if (take_chk) begin
        op_q   <= OP_CHECK;
        dest_q <= chk_dest;
        len_q  <= chk_len;
      end else if (take_ml) begin
        op_q   <= OP_LOAD;
        dest_q <= ml_addr;
      end
      if (ml_start) begin
        quota_q <= quota_cap;
      end else if (take_ml) begin
        quota_q <= quota_q - QW'(1);
      end
    end
  end

  daf_crc_serial #(.NBYTES(NBYTES), .HASH_W(HASH_W)) u_crc (
    .clk      (clk),
    .rst      (rst),
    .start    (take_chk | take_ml),
    .din      (take_chk ? chk_dest : ml_addr),
    .busy     (busy),
    .done     (done),
    .hash_idx (idx)
  );

  daf_hash_table #(.IDX_W(HASH_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .clr     (ml_start),
    .set_en  (done && (op_q == OP_LOAD)),
    .set_idx (idx),
    .rd_idx  (idx),
    .rd_bit  (hit)
  );

  daf_decide #(.MAC_W(MAC_W), .LEN_W(LEN_W)) u_dec (
    .dest      (dest_q),
    .len       (len_q),
    .min_len   (cfg_min_len),
    .promisc   (cfg_promisc),
    .bcast_off (cfg_bcast_off),
    .mcast_en  (cfg_mcast_en),
    .station   (station_addr),
    .hash_hit  (hit),
    .accept    (dec_acc),
    .group     (dec_grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reject <= 1'b0;
      res_group  <= 1'b0;
    end else if (done && (op_q == OP_CHECK)) begin
      res_valid  <= 1'b1;
      res_accept <= dec_acc;
      res_reject <= !dec_acc;
      res_group  <= dec_acc && dec_grp;
    end else begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reject <= 1'b0;
      res_group  <= 1'b0;
    end
  end

  // R1: result shape
  a_r1_one_of_two: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_accept ^ res_reject));
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_accept || res_reject || res_group));
  a_r1_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R2: a frame under the floor never passes
  a_r2_floor: assert property (@(posedge clk) disable iff (rst)
    (res_valid && ($past(len_q) < LEN_W'(MIN_LEN_FLOOR))) |-> res_reject);
  // R3: promiscuous acceptance carries no group flag
  a_r3_promisc_flag: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(cfg_promisc)) |-> !res_group);
  // R8: quota never exceeds the table size
  a_r8_quota_cap: assert property (@(posedge clk) disable iff (rst)
    quota_q <= QW'(TBL));

endmodule

// File: tb/test_da_filter.sv
module test_da_filter;

  localparam int LEN_W = 14;
  localparam int CNT_W = 16;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_promisc = 1'b0, cfg_bcast_off = 1'b0, cfg_mcast_en = 1'b0;
  logic [7:0]       cfg_min_len = 8'd0;
  logic [47:0]      station_addr = 48'h02_11_22_33_44_55;
  logic             chk_valid = 1'b0;
  logic [47:0]      chk_dest = '0;
  logic [LEN_W-1:0] chk_len = '0;
  logic             ml_start = 1'b0;
  logic [CNT_W-1:0] ml_bytes = '0;
  logic             ml_valid = 1'b0;
  logic [47:0]      ml_addr = '0;
  logic             res_valid, res_accept, res_reject, res_group;

  da_filter #(.LEN_W(LEN_W), .HASH_W(6), .CNT_W(CNT_W)) i_da_filter (
    .clk(clk), .rst(rst),
    .cfg_promisc(cfg_promisc), .cfg_bcast_off(cfg_bcast_off),
    .cfg_mcast_en(cfg_mcast_en), .cfg_min_len(cfg_min_len),
    .station_addr(station_addr),
    .chk_valid(chk_valid), .chk_dest(chk_dest), .chk_len(chk_len),
    .ml_start(ml_start), .ml_bytes(ml_bytes), .ml_valid(ml_valid), .ml_addr(ml_addr),
    .res_valid(res_valid), .res_accept(res_accept),
    .res_reject(res_reject), .res_group(res_group)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  int    cyc = 0;
  bit    ended = 0;
  logic [63:0] mtbl = '0;
  int    mquota = 0;

  logic [1:0] exp_q[$];
  int         when_q[$];
  string      tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] m_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int j = 0; j < 6; j++) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ a[47 - 8*j - 7 + i];
        c  = c >> 1;
        if (fb) c = c ^ POLY;
      end
    end
    return c[7:2];
  endfunction

  function automatic logic [1:0] model(input logic [47:0] d, input int l);
    int mn;
    mn = (cfg_min_len < 5) ? 5 : int'(cfg_min_len);
    if (l < mn) return 2'b00;
    if (cfg_promisc) return 2'b10;
    if (&d) return cfg_bcast_off ? 2'b00 : 2'b11;
    if (d[40]) begin
      if (!cfg_mcast_en) return 2'b00;
      return mtbl[m_idx(d)] ? 2'b11 : 2'b00;
    end
    return (d == station_addr) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [47:0] find_free(input logic [47:0] base);
    for (int k = 0; k < 4096; k++) begin
      if (!mtbl[m_idx(base + 48'(k))]) return base + 48'(k);
    end
    return base;
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver: pulse a check strobe; optionally push the expected result
  task automatic strobe_chk(input logic [47:0] d, input int l, input string tag, input bit expect_it);
    @(negedge clk);
    chk_dest = d; chk_len = LEN_W'(l); chk_valid = 1'b1;
    if (expect_it) begin
      exp_q.push_back(model(d, l));
      when_q.push_back(cyc + 8);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic check(input logic [47:0] d, input int l, input string tag);
    strobe_chk(d, l, tag, 1);
    repeat (7) @(negedge clk);
  endtask

  task automatic ml_begin(input int bytes);
    @(negedge clk);
    ml_bytes = CNT_W'(bytes); ml_start = 1'b1;
    @(negedge clk);
    ml_start = 1'b0;
    mtbl = '0;
    mquota = (bytes / 6 > 64) ? 64 : bytes / 6;
  endtask

  task automatic ml_add(input logic [47:0] a);
    @(negedge clk);
    ml_addr = a; ml_valid = 1'b1;
    if (mquota > 0) begin
      mtbl[m_idx(a)] = 1'b1;
      mquota--;
    end
    @(negedge clk);
    ml_valid = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9 unexpected result: acc=%0b exp no result", res_accept);
      end else begin
        logic [1:0] e;
        int         w;
        string      t;
        e = exp_q.pop_front(); w = when_q.pop_front(); t = tag_q.pop_front();
        if (res_accept !== e[1] || res_reject !== !e[1] || res_group !== e[0] || cyc != w) begin
          n_bad++;
          $display("FAIL %s: acc/rej/grp=%0b%0b%0b cyc=%0d exp %0b%0b%0b cyc=%0d",
                   t, res_accept, res_reject, res_group, cyc, e[1], !e[1], e[0], w);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, exp done got hung");
    summary();
  end

  initial begin
    logic [47:0] mc_a, mc_b, mc_c, miss, extra;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    n_cmp++;
    if (res_valid || res_accept || res_reject || res_group) begin
      n_bad++;
      $display("FAIL R10 reset outputs %0b%0b%0b%0b exp 0000", res_valid, res_accept, res_reject, res_group);
    end
    cfg_mcast_en = 1'b1;
    check(48'h01_00_5E_00_00_01, 64, "R10 empty table");
    cfg_mcast_en = 1'b0;

    // R6 unicast
    check(station_addr, 64, "R6 exact match");
    check(48'h02_11_22_33_44_54, 64, "R6 one bit off");
    check(48'h00_00_00_00_00_00, 64, "R6 zero dest");
    // R4 broadcast
    check('1, 64, "R4 broadcast accept");
    cfg_bcast_off = 1'b1;
    check('1, 64, "R4 broadcast disabled");
    cfg_bcast_off = 1'b0;
    // R5 multicast gate off
    check(48'h01_00_5E_00_00_07, 64, "R5 mcast disabled");

    // R7/R8 load a list of three and check hits and a miss
    mc_a = 48'h01_00_5E_00_00_07;
    mc_b = 48'h33_33_00_00_00_01;
    mc_c = 48'h01_80_C2_00_00_0E;
    ml_begin(18);
    ml_add(mc_a); ml_add(mc_b); ml_add(mc_c);
    cfg_mcast_en = 1'b1;
    check(mc_a, 64, "R7 hash hit a");
    check(mc_b, 64, "R7 hash hit b");
    check(mc_c, 64, "R5 hash hit c");
    miss = find_free(48'h01_00_5E_10_00_00);
    check(miss, 64, "R5 hash miss");

    // R2 length floor and configured minimum
    check(station_addr, 4, "R2 below floor");
    check(station_addr, 5, "R2 at floor");
    cfg_min_len = 8'd60;
    check(station_addr, 59, "R2 below min");
    check(station_addr, 60, "R2 at min");
    cfg_promisc = 1'b1;
    check(48'h02_99_99_99_99_99, 59, "R2 short in promisc");
    // R3 promiscuous
    check(48'h02_99_99_99_99_99, 60, "R3 foreign unicast");
    cfg_bcast_off = 1'b1;
    check('1, 60, "R3 broadcast overrides disable");
    check(miss, 60, "R3 multicast miss");
    cfg_bcast_off = 1'b0;
    cfg_promisc = 1'b0;
    cfg_min_len = 8'd0;

    // R9 strobe while busy is ignored
    strobe_chk(station_addr, 64, "R9 first kept", 1);
    repeat (2) @(negedge clk);
    strobe_chk(48'h02_00_00_00_00_01, 64, "R9 second dropped", 0);
    repeat (8) @(negedge clk);
    // R9 check wins over a simultaneous load
    ml_begin(6);
    extra = find_free(48'h01_00_5E_20_00_00);
    @(negedge clk);
    chk_dest = station_addr; chk_len = 14'd64; chk_valid = 1'b1;
    ml_addr = extra; ml_valid = 1'b1;
    exp_q.push_back(model(station_addr, 64)); when_q.push_back(cyc + 8); tag_q.push_back("R9 check wins");
    @(negedge clk);
    chk_valid = 1'b0; ml_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(extra, 64, "R9 load not taken");

    // R8 reload clears, quota of 2 from 13 bytes
    ml_begin(13);
    check(mc_a, 64, "R8 clear on start");
    ml_add(mc_a); ml_add(mc_b);
    extra = find_free(48'h01_00_5E_30_00_00);
    ml_add(extra);
    check(extra, 64, "R8 quota exhausted");
    check(mc_b, 64, "R8 within quota");

    // R8 cap at 64 entries
    ml_begin(400);
    for (int k = 0; k < 64; k++) ml_add(48'h01_00_5E_40_00_00 + 48'(k));
    extra = find_free(48'h01_00_5E_50_00_00);
    ml_add(extra);
    check(extra, 64, "R8 cap at 64");
    check(48'h01_00_5E_40_00_3F, 64, "R8 last in cap");

    repeat (4) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 missing results: %0d left exp 0", exp_q.size());
    end
    summary();
  end

endmodule